// File: doc/BRIEF.md
# Blank-First Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display. It uses one pixel counter and one line counter. Count zero on each axis is the first position of the blanking interval, and the visible region fills the tail of the line or frame. Every programmed position is therefore measured from the point where active video ends.

The block puts out the two sync pulses, a display-enable strobe, and the pixel and line coordinates inside the visible window. The configuration inputs can change at any time. They are copied into a shadow set only when the frame wraps, so a new mode always starts cleanly at count (0,0).

The horizontal settings are:
- the line length minus one;
- the sync start and sync end columns, as offsets from the end of active video;
- the first visible column, which is the line length minus the visible width.

The vertical settings are:
- the frame length minus one;
- the sync start and sync end rows, each written as its offset minus one;
- the first visible row.

Each sync pulse has its own polarity bit.

Top module: `vtg_blankfirst`

## Requirements
- R1: The pixel counter starts at 0 after reset and steps by one each clock. After it reaches the shadowed line-length-minus-one value, it returns to 0, so a line lasts that value plus one clocks.
- R2: The line counter steps by one only on the clock where the pixel counter wraps. After it reaches the shadowed frame-length-minus-one value, it returns to 0.
- R3: The raw horizontal sync is active while the pixel count is at least the sync start column and below the sync end column.
- R4: The raw vertical sync is active while the line count is at least sync start plus one and below sync end plus one, because both vertical sync values are stored as offset minus one.
- R5: The sync output follows its raw sync when its polarity bit is 1 (active high). It is the inverse of the raw sync when the bit is 0 (active low).
- R6: Display enable is 1 exactly when the pixel count is at or above the first visible column and the line count is at or above the first visible row.
- R7: While display enable is 1, pix_x equals the pixel count minus the first visible column and pix_y equals the line count minus the first visible row. While display enable is 0, both are 0.
- R8: The configuration inputs are copied into the shadow set only in the reset cycle and on the clock where both counters wrap together. A change made mid-frame has no effect on any output until the counters return to (0,0).
- R9: While reset is low, both counters are held at 0 and the shadow set loads the inputs. Display enable and both coordinates are then 0, and each sync output sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_h_total_m1 | input | HW | Line length minus one |
| cfg_h_sync_beg | input | HW | Horizontal sync start column (offset from end of active video) |
| cfg_h_sync_fin | input | HW | Horizontal sync end column (start plus width) |
| cfg_h_act_beg | input | HW | First visible column (line length minus width) |
| cfg_v_total_m1 | input | VW | Frame length minus one |
| cfg_v_sync_beg | input | VW | Vertical sync start offset minus one |
| cfg_v_sync_fin | input | VW | Vertical sync end offset minus one |
| cfg_v_act_beg | input | VW | First visible row (frame length minus height) |
| cfg_hs_high | input | 1 | Horizontal sync polarity, 1 = active high |
| cfg_vs_high | input | 1 | Vertical sync polarity, 1 = active high |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| pix_x | output | HW | Column inside the visible window |
| pix_y | output | VW | Row inside the visible window |

## Verification
All outputs are decoded without a register from the two counters and the shadow set. Each output therefore reflects the count in the same cycle, and the count moves one step per rising edge after reset is released. A configuration change shows up first in the cycle where the counters read (0,0) after the next frame wrap.

The bench advances its own pixel and line count on the rising edge, using the rules in the requirements. It samples every output on the falling edge, so it sees the settled result for the count it holds. On top of that cycle-by-cycle comparison, directed tasks:
- stop at chosen (column, row) positions and compare against literal values;
- time line and frame periods between sync edges;
- change the configuration mid-frame to confirm it takes effect only at the frame boundary.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Working width of every position field; the top module's HW and VW must not exceed it.
  localparam int CW = 16;

  typedef struct packed {
    logic [CW-1:0] total_m1;
    logic [CW-1:0] sync_beg;
    logic [CW-1:0] sync_fin;
    logic [CW-1:0] act_beg;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t h;
    axis_cfg_t v;
    logic      hs_high;
    logic      vs_high;
  } tmg_cfg_t;

  // Half-open window test: beg <= c < fin.
  function automatic logic span_hit(logic [CW-1:0] c, logic [CW-1:0] beg, logic [CW-1:0] fin);
    return (c >= beg) && (c < fin);
  endfunction

  // Polarity: high=1 passes the raw pulse through, high=0 inverts it.
  function automatic logic drive_level(logic raw, logic high);
    return high ? raw : ~raw;
  endfunction

  // Offset of a count inside the visible window, zero when outside it.
  function automatic logic [CW-1:0] rel_coord(logic [CW-1:0] c, logic [CW-1:0] base, logic on);
    return on ? (c - base) : '0;
  endfunction

endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  tmg_cfg_t cfg_in,
  output tmg_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || take) cfg_q <= cfg_in;
  end

  // R8: the shadow set only moves at a frame wrap
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cfg_q));

  // R8: at a frame wrap the live inputs are captured
  a_r8_shadow_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cfg_q == $past(cfg_in));

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int W         = 12,
  parameter bit LINE_BIAS = 1'b0
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  axis_cfg_t     cfg,
  output logic [W-1:0]  cnt,
  output logic          at_end,
  output logic          sync_hit,
  output logic          in_act,
  output logic [W-1:0]  coord
);

  logic [CW-1:0] cnt_x;
  assign cnt_x  = CW'(cnt);
  assign at_end = cnt_x >= cfg.total_m1;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= at_end ? '0 : cnt + W'(1);
  end

  // The vertical sync fields are stored one below the real row, so the window is shifted up by one.
  generate
    if (LINE_BIAS) begin : g_biased
      assign sync_hit = span_hit(cnt_x, cfg.sync_beg + CW'(1), cfg.sync_fin + CW'(1));
    end else begin : g_plain
      assign sync_hit = span_hit(cnt_x, cfg.sync_beg, cfg.sync_fin);
    end
  endgenerate

  assign in_act = cnt_x >= cfg.act_beg;
  assign coord  = W'(rel_coord(cnt_x, cfg.act_beg, in_act));

  // R1: a step below the limit advances by exactly one
  a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    step && !at_end |=> cnt == $past(cnt) + W'(1));

  // R1: a step at the limit returns the counter to zero
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_end |=> cnt == '0);

  // R2: without a step the count holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));

  // R1: the count never passes the shadowed limit
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_x <= cfg.total_m1);

endmodule

// File: rtl/vtg_blankfirst.sv
module vtg_blankfirst
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_h_total_m1,
  input  logic [HW-1:0] cfg_h_sync_beg,
  input  logic [HW-1:0] cfg_h_sync_fin,
  input  logic [HW-1:0] cfg_h_act_beg,
  input  logic [VW-1:0] cfg_v_total_m1,
  input  logic [VW-1:0] cfg_v_sync_beg,
  input  logic [VW-1:0] cfg_v_sync_fin,
  input  logic [VW-1:0] cfg_v_act_beg,
  input  logic          cfg_hs_high,
  input  logic          cfg_vs_high,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] pix_y
);

  tmg_cfg_t cfg_live;
  tmg_cfg_t sh;

  assign cfg_live.h.total_m1 = CW'(cfg_h_total_m1);
  assign cfg_live.h.sync_beg = CW'(cfg_h_sync_beg);
  assign cfg_live.h.sync_fin = CW'(cfg_h_sync_fin);
  assign cfg_live.h.act_beg  = CW'(cfg_h_act_beg);
  assign cfg_live.v.total_m1 = CW'(cfg_v_total_m1);
  assign cfg_live.v.sync_beg = CW'(cfg_v_sync_beg);
  assign cfg_live.v.sync_fin = CW'(cfg_v_sync_fin);
  assign cfg_live.v.act_beg  = CW'(cfg_v_act_beg);
  assign cfg_live.hs_high    = cfg_hs_high;
  assign cfg_live.vs_high    = cfg_vs_high;

  // Events shared by the sub-blocks, named for the assertions.
  logic          h_end, v_end, h_wrap, frame_wrap;
  logic          h_hit, v_hit, h_act, v_act;
  logic [HW-1:0] h_cnt, h_coord;
  logic [VW-1:0] v_cnt, v_coord;

  assign h_wrap     = h_end;
  assign frame_wrap = h_end && v_end;

  vtg_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (frame_wrap),
    .cfg_in (cfg_live),
    .cfg_q  (sh)
  );

  vtg_axis #(.W(HW), .LINE_BIAS(1'b0)) u_h_axis (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (1'b1),
    .cfg      (sh.h),
    .cnt      (h_cnt),
    .at_end   (h_end),
    .sync_hit (h_hit),
    .in_act   (h_act),
    .coord    (h_coord)
  );

  vtg_axis #(.W(VW), .LINE_BIAS(1'b1)) u_v_axis (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (h_wrap),
    .cfg      (sh.v),
    .cnt      (v_cnt),
    .at_end   (v_end),
    .sync_hit (v_hit),
    .in_act   (v_act),
    .coord    (v_coord)
  );

  assign hsync = drive_level(h_hit, sh.hs_high);
  assign vsync = drive_level(v_hit, sh.vs_high);
  assign de    = h_act && v_act;
  assign pix_x = de ? h_coord : '0;
  assign pix_y = de ? v_coord : '0;

  // R5: outside the sync window each output rests at the inactive level
  a_r5_hs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !h_hit |-> hsync != sh.hs_high);
  a_r5_vs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !v_hit |-> vsync != sh.vs_high);

  // R2: a frame wrap brings both counters back to the blanking origin
  a_r2_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (h_cnt == '0) && (v_cnt == '0));

  // R6: display enable only inside the visible column range
  a_r6_de_column: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> CW'(h_cnt) >= sh.h.act_beg);

  // R7: coordinates rest at zero during blanking
  a_r7_coord_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pix_x == '0) && (pix_y == '0));

endmodule

// File: tb/vtg_blankfirst_bench.sv
module vtg_blankfirst_bench;

  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] h_tot, h_sb, h_sf, h_ab;
  logic [VW-1:0] v_tot, v_sb, v_sf, v_ab;
  logic hs_hi, vs_hi;
  logic hsync, vsync, de;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit chk_on = 0;

  always #2 clk = ~clk;

  vtg_blankfirst #(.HW(HW), .VW(VW)) u_vtg_blankfirst (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_total_m1(h_tot), .cfg_h_sync_beg(h_sb), .cfg_h_sync_fin(h_sf), .cfg_h_act_beg(h_ab),
    .cfg_v_total_m1(v_tot), .cfg_v_sync_beg(v_sb), .cfg_v_sync_fin(v_sf), .cfg_v_act_beg(v_ab),
    .cfg_hs_high(hs_hi), .cfg_vs_high(vs_hi),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y)
  );

  // Independent position model, stepped on the rising edge.
  int mh, mv;
  int s_ht, s_hsb, s_hsf, s_hab, s_vt, s_vsb, s_vsf, s_vab;
  bit s_hp, s_vp;

  task automatic load_model;
    s_ht = int'(h_tot); s_hsb = int'(h_sb); s_hsf = int'(h_sf); s_hab = int'(h_ab);
    s_vt = int'(v_tot); s_vsb = int'(v_sb); s_vsf = int'(v_sf); s_vab = int'(v_ab);
    s_hp = hs_hi; s_vp = vs_hi;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; load_model();
    end else if (mh >= s_ht) begin
      mh = 0;
      if (mv >= s_vt) begin mv = 0; load_model(); end
      else mv = mv + 1;
    end else begin
      mh = mh + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at h=%0d v=%0d: actual=%0d expected=%0d", req, mh, mv, act, exp);
    end
  endtask

  // Per-cycle comparison against the requirement formulas.
  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      bit hr, vr, e_de;
      hr   = (mh >= s_hsb) && (mh < s_hsf);
      vr   = (mv - 1 >= s_vsb) && (mv - 1 < s_vsf);
      e_de = (mh >= s_hab) && (mv >= s_vab);
      check("R3/R5 hsync", int'(hsync), int'(s_hp ? hr : !hr));
      check("R4/R5 vsync", int'(vsync), int'(s_vp ? vr : !vr));
      check("R6 de", int'(de), int'(e_de));
      check("R7 pix_x", int'(pix_x), e_de ? mh - s_hab : 0);
      check("R7 pix_y", int'(pix_y), e_de ? mv - s_vab : 0);
    end
  end

  task automatic wait_pos(int h, int v);
    do @(negedge clk); while (!(mh == h && mv == v));
  endtask

  // Line 20 clocks, visible 12 (first column 8), sync columns 2..4;
  // frame 10 lines, visible 6 (first row 4), sync rows 1..2 stored as 0 and 2.
  task automatic set_default;
    h_tot = 19; h_sb = 2; h_sf = 5; h_ab = 8;
    v_tot = 9;  v_sb = 0; v_sf = 2; v_ab = 4;
    hs_hi = 1'b1; vs_hi = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    set_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 de in reset", int'(de), 0);
    check("R9 pix_x in reset", int'(pix_x), 0);
    check("R9 pix_y in reset", int'(pix_y), 0);
    check("R9 hsync idle in reset", int'(hsync), 0);
    check("R9 vsync idle in reset", int'(vsync), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
  endtask

  task automatic t_hsync_cols;
    wait_pos(1, 0); check("R3 col 1", int'(hsync), 0);
    wait_pos(2, 0); check("R3 col 2", int'(hsync), 1);
    wait_pos(4, 0); check("R3 col 4", int'(hsync), 1);
    wait_pos(5, 0); check("R3 col 5", int'(hsync), 0);
  endtask

  task automatic t_vsync_rows;
    wait_pos(0, 0); check("R4 row 0", int'(vsync), 0);
    wait_pos(0, 1); check("R4 row 1", int'(vsync), 1);
    wait_pos(0, 2); check("R4 row 2", int'(vsync), 1);
    wait_pos(0, 3); check("R4 row 3", int'(vsync), 0);
  endtask

  task automatic t_active;
    wait_pos(8, 3);  check("R6 row 3 blank", int'(de), 0);
    wait_pos(7, 4);  check("R6 col 7 blank", int'(de), 0);
    wait_pos(8, 4);  check("R6 first pixel", int'(de), 1);
    check("R7 x origin", int'(pix_x), 0);
    check("R7 y origin", int'(pix_y), 0);
    wait_pos(19, 4); check("R7 last column", int'(pix_x), 11);
    wait_pos(19, 9); check("R7 last row", int'(pix_y), 5);
    @(negedge clk);  check("R2 frame wrap to blank", int'(de), 0);
  endtask

  task automatic t_periods;
    logic p;
    int n;
    do begin p = hsync; @(negedge clk); end while (!(p == 1'b0 && hsync == 1'b1));
    n = 0;
    do begin p = hsync; @(negedge clk); n++; end while (!(p == 1'b0 && hsync == 1'b1));
    check("R1 line period", n, 20);
    do begin p = vsync; @(negedge clk); end while (!(p == 1'b0 && vsync == 1'b1));
    n = 0;
    begin
      logic ph, pv;
      do begin
        ph = hsync; pv = vsync; @(negedge clk);
        if (ph == 1'b0 && hsync == 1'b1) n++;
      end while (!(pv == 1'b0 && vsync == 1'b1));
    end
    check("R2 lines per frame", n, 10);
  endtask

  task automatic t_shadow;
    wait_pos(3, 5);
    h_tot = 23; hs_hi = 1'b0;
    wait_pos(2, 7);  check("R8 old polarity kept", int'(hsync), 1);
    wait_pos(19, 7); check("R8 old length kept", int'(pix_x), 11);
    @(negedge clk);  check("R8 wraps at old length", int'(de), 0);
    wait_pos(0, 0);
    wait_pos(2, 0);  check("R8 new polarity", int'(hsync), 0);
    wait_pos(23, 5); check("R8 new length", int'(pix_x), 15);
    h_tot = 19; hs_hi = 1'b1;
    wait_pos(0, 0);
  endtask

  task automatic t_polarity;
    wait_pos(5, 5);
    vs_hi = 1'b0;
    wait_pos(0, 0); check("R5 vsync low-active idle", int'(vsync), 1);
    wait_pos(0, 1); check("R5 vsync low-active pulse", int'(vsync), 0);
    vs_hi = 1'b1;
    wait_pos(0, 0); check("R5 vsync restored", int'(vsync), 0);
  endtask

  initial begin
    set_default();
    t_reset();
    t_hsync_cols();
    t_vsync_rows();
    t_active();
    t_periods();
    t_shadow();
    t_polarity();
    t_reset();
    t_hsync_cols();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R1 timeout: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule